// File: doc/BRIEF.md
# Pipelined LUT Reciprocal Unit

This unit gives an approximate fixed-point reciprocal of an unsigned operand without a divider. Its target is floor(2^SCALE / den). It uses it in places such as a per-pixel perspective divide, where one result per clock matters more than exact rounding.

The operand is first normalised by locating its most significant set bit. The IDX_BITS bits just below that bit select an entry in a mantissa-reciprocal table. The table is computed when the design is elaborated, so it needs no external file. The table value is then shifted right by the normalisation amount and saturated to the output width.

The unit streams with a valid flag. It accepts one operand on every clock and has no backpressure. A zero operand gives a defined, saturated result. Raising IDX_BITS makes the table larger and the result more accurate.

Top module: `lut_recip`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 3 clock cycles. An operand is accepted on every cycle that `in_valid` is high, with no gaps required.
- R2: While `rst_n` is low (asynchronous, active low), `out_valid` is 0 and `recip` is 0. `out_valid` stays 0 for the first three clocks after reset is released.
- R3: An operand of 0 returns `recip` with all OUT_W bits set to 1.
- R4: An operand of 1 returns 2^SCALE, saturated to 2^OUT_W-1 if it does not fit. With the default values this is 16777216.
- R5: An operand 2^k (k = 0 .. Q_W-1) returns exactly floor(2^SCALE / 2^k).
- R6: With IDX_BITS = 8, every nonzero operand returns a value within floor(2^SCALE/den)·1.5/256 + 2 of floor(2^SCALE/den).
- R7: With IDX_BITS = 11 (2048 table entries), the same bound tightens to floor(2^SCALE/den)·1.5/2048 + 2, which is about 0.07%.
- R8: Results leave in the same order as their operands entered, one result per accepted operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand on `den` is valid this cycle |
| den | input | Q_W | Unsigned operand |
| out_valid | output | 1 | `recip` holds a result this cycle |
| recip | output | OUT_W | Approximate floor(2^SCALE / den) |

## Verification
The bound checker watches every cycle for the following:
- the 3-cycle valid delay;
- the quiet output just after reset;
- the saturated zero-operand result;
- the exact result for an operand of 1.

Only the bench scenarios can show the following:
- the accuracy bounds at both table sizes, over many random operands;
- the exact results for powers of two;
- result ordering under back-to-back and gapped input.

The bench checks these against an exact integer division.

// File: rtl/lut_recip.sv
module lut_recip #(
  parameter int Q_W      = 24,
  parameter int IDX_BITS = 8,
  parameter int SCALE    = 24,
  parameter int OUT_W    = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [Q_W-1:0]   den,
  output logic             out_valid,
  output logic [OUT_W-1:0] recip
);
  localparam int PW   = $clog2(Q_W);
  localparam int FR   = IDX_BITS + 2;
  localparam int TW   = FR + 1;
  localparam int WW   = TW + SCALE;
  localparam int EW   = (WW > OUT_W) ? WW : OUT_W;
  localparam int NENT = 1 << IDX_BITS;

  logic [TW-1:0] tbl [NENT];
  for (genvar f = 0; f < NENT; f++) begin : g_tbl
    localparam longint NUM = longint'(1) << (FR + IDX_BITS + 1);
    localparam longint DNM = (longint'(1) << IDX_BITS) + longint'(f);
    assign tbl[f] = TW'((NUM / DNM + 1) / 2);
  end

  logic [PW-1:0]       lead;
  logic [Q_W-1:0]      norm;
  logic [IDX_BITS-1:0] idx;
  always_comb begin
    lead = '0;
    for (int i = 0; i < Q_W; i++)
      if (den[i]) lead = PW'(i);
  end
  assign norm = den << (Q_W - 1 - int'(lead));
  assign idx  = IDX_BITS'(norm >> (Q_W - 1 - IDX_BITS));

  logic                v1, z1, v2, z2;
  logic [PW-1:0]       p1, p2;
  logic [IDX_BITS-1:0] f1;
  logic [TW-1:0]       t2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; z1 <= 1'b0; p1 <= '0; f1 <= '0;
      v2 <= 1'b0; z2 <= 1'b0; p2 <= '0; t2 <= '0;
    end else begin
      v1 <= in_valid; z1 <= (den == '0); p1 <= lead; f1 <= idx;
      v2 <= v1;       z2 <= z1;          p2 <= p1;   t2 <= tbl[f1];
    end
  end

  logic [WW-1:0] wide;
  logic [EW-1:0] ext;
  logic          sat;
  assign wide = {t2, {SCALE{1'b0}}} >> (int'(p2) + FR);
  assign ext  = EW'(wide);
  assign sat  = z2 || (ext > EW'({OUT_W{1'b1}}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      recip     <= '0;
    end else begin
      out_valid <= v2;
      recip     <= sat ? '1 : OUT_W'(ext);
    end
  end
endmodule

// File: rtl/lut_recip_chk.sv
module lut_recip_chk #(
  parameter int Q_W   = 24,
  parameter int SCALE = 24,
  parameter int OUT_W = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [Q_W-1:0]   den,
  input logic             out_valid,
  input logic [OUT_W-1:0] recip
);
  localparam longint unsigned PWR  = longint'(1) << SCALE;
  localparam longint unsigned MAXO = (longint'(1) << OUT_W) - 1;
  localparam longint unsigned ONE_R = (PWR > MAXO) ? MAXO : PWR;

  logic [1:0] cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (cnt != 2'd3) cnt <= cnt + 2'd1;

  // R2
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 2'd3) |-> !out_valid);

  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R3
  zero_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd3 && $past(in_valid, 3) && $past(den, 3) == '0) |-> (recip == '1));

  // R4
  unit_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd3 && $past(in_valid, 3) && $past(den, 3) == Q_W'(1)) |-> (recip == OUT_W'(ONE_R)));
endmodule

bind lut_recip lut_recip_chk #(.Q_W(Q_W), .SCALE(SCALE), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .den(den),
  .out_valid(out_valid), .recip(recip)
);

// File: tb/lut_recip_tb.sv
`timescale 1ns/1ps
module lut_recip_tb;
  localparam int QW = 24, SC = 24, OW = 25;
  localparam longint unsigned MAXO = (longint'(1) << OW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [QW-1:0] den = '0;
  logic ov_a, ov_b;
  logic [OW-1:0] r_a, r_b;

  always #10 clk = ~clk;

  lut_recip #(.Q_W(QW), .IDX_BITS(8), .SCALE(SC), .OUT_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .den(den), .out_valid(ov_a), .recip(r_a));
  lut_recip #(.Q_W(QW), .IDX_BITS(11), .SCALE(SC), .OUT_W(OW)) u_dut_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .den(den), .out_valid(ov_b), .recip(r_b));

  int n_cmp = 0, n_bad = 0;
  typedef struct { bit v; longint unsigned d; } ent_t;
  ent_t hist[$];

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic check_one(string tag, bit ov, logic [OW-1:0] r, int ib, ent_t e);
    longint unsigned ex;
    real tol, diff;
    n_cmp++;
    if (ov !== e.v) begin
      n_bad++;
      $display("FAIL R1/R8 %s out_valid act=%0b exp=%0b", tag, ov, e.v);
      return;
    end
    if (!e.v) return;
    ex = (e.d == 0) ? MAXO : ((longint'(1) << SC) / e.d);
    if (ex > MAXO) ex = MAXO;
    n_cmp++;
    if (e.d == 0) begin
      if (r !== OW'(MAXO)) begin n_bad++;
        $display("FAIL R3 %s den=0 act=%0d exp=%0d", tag, r, MAXO); end
    end else if (e.d == 1) begin
      if (r !== OW'(ex)) begin n_bad++;
        $display("FAIL R4 %s den=1 act=%0d exp=%0d", tag, r, ex); end
    end else if ((e.d & (e.d - 1)) == 0) begin
      if (r !== OW'(ex)) begin n_bad++;
        $display("FAIL R5 %s den=%0d act=%0d exp=%0d", tag, e.d, r, ex); end
    end else begin
      tol  = real'(ex) * 1.5 / real'(longint'(1) << ib) + 2.0;
      diff = real'(r) - real'(ex);
      if (diff < 0.0) diff = -diff;
      if (diff > tol) begin n_bad++;
        $display("FAIL %s %s den=%0d act=%0d exp=%0d", (ib == 8) ? "R6" : "R7", tag, e.d, r, ex); end
    end
  endtask

  task automatic step(bit v, longint unsigned d);
    ent_t e, n;
    @(negedge clk);
    if (hist.size() == 3) begin
      e = hist.pop_front();
      check_one("idx8", ov_a, r_a, 8, e);
      check_one("idx11", ov_b, r_b, 11, e);
    end
    in_valid = v;
    den = QW'(d);
    n.v = v; n.d = d & ((longint'(1) << QW) - 1);
    hist.push_back(n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    ent_t idle;
    idle.v = 1'b0; idle.d = 0;
    repeat (3) begin
      @(negedge clk);
      n_cmp++;
      if (ov_a !== 1'b0 || r_a !== '0 || ov_b !== 1'b0 || r_b !== '0) begin
        n_bad++;
        $display("FAIL R2 reset outputs act=%0b/%0d exp=0/0", ov_a, r_a);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) hist.push_back(idle);
    step(1, 0); step(1, 1); step(1, 2); step(1, 3);
    step(0, 5); step(1, 255); step(1, 256); step(1, 257);
    step(1, (longint'(1) << QW) - 1);
    step(0, 0);
    for (int k = 0; k < QW; k++) step(1, longint'(1) << k);
    for (int k = 0; k < QW; k++) step(1, (longint'(1) << k) + 1);
    for (int k = 2; k < QW; k++) step(1, (longint'(1) << k) - 1);
    for (int i = 0; i < 3000; i++) begin
      longint unsigned d;
      d = longint'($urandom) >> ($urandom % 32);
      step(($urandom % 4) != 0, d);
    end
    repeat (4) step(0, 0);
    summary();
    $finish;
  end
endmodule